// File: doc/BRIEF.md
# Call and Return Stack Controller

This block sequences the stack traffic of a small 8-bit processor core. The stack grows upward in byte-wide internal RAM and is addressed by an 8-bit stack pointer held inside the block. When the core decodes a subroutine call, a return, a return from an interrupt handler, or a single-byte push or pop, it raises one request strobe. The block then issues the RAM accesses one byte per cycle, moves the stack pointer, and for calls and returns delivers the new program counter together with a load strobe.

Two call forms exist. The far call jumps to any 16-bit address. The page call keeps the upper five bits of the next-instruction address and replaces the lower eleven bits with the supplied target. A return and an interrupt return both rebuild a 16-bit address from two stack bytes. The interrupt return also pulses a release line that lets the interrupt controller accept new interrupts at the level just serviced. It never touches the status word. Push stores a byte that the core supplies. Pop reads the top byte and writes it to an 8-bit direct address.

The controller is a single state machine with nine states. ST_IDLE waits for a request. A call runs through ST_CALL_LO and then ST_CALL_HI. A return runs through ST_RET_HI, ST_RET_LO and ST_RET_FIN. A push uses only ST_PUSH_WR. A pop runs through ST_POP_RD and then ST_POP_WR. Every final state sends the machine back to ST_IDLE, and each state in a sequence moves unconditionally to the next one.

Top module: `callstack_ctrl`

## Requirements
- R1: After reset the stack pointer is 0x07, and ram_we, ram_re, done, pc_load and irq_release are all low.
- R2: A far call accepted at edge E writes next_pc[7:0] to address SP+1 in the first cycle after E. It writes next_pc[15:8] to address SP+2 in the second cycle. In that second cycle it asserts pc_load with pc_new equal to call_tgt. The stack pointer finishes at SP+2.
- R3: A page call follows the same sequence as R2, except that pc_new equals {next_pc[15:11], call_tgt[10:0]}.
- R4: A return reads address SP in cycle 1 and address SP-1 in cycle 2. RAM read data arrives one cycle after ram_re. In cycle 3 it asserts pc_load with pc_new = {byte at SP, byte at SP-1}. The stack pointer finishes at SP-2, and irq_release stays low throughout.
- R5: An interrupt return behaves exactly like R4, except that irq_release is high in cycle 3. No RAM write occurs at any point in the sequence.
- R6: A push writes push_data to address SP+1 in the first cycle after acceptance, and the stack pointer becomes SP+1.
- R7: A pop reads address SP in cycle 1. In cycle 2 it writes that byte to dir_addr. The stack pointer finishes at SP-1.
- R8: The stack pointer and every stack address wrap modulo 256.
- R9: Requests are accepted only in the idle state, and a request raised while busy has no effect. When several requests arrive together, the priority order is far call, then page call, then return, then interrupt return, then push, then pop.
- R10: done is high for exactly one cycle, the final cycle of each sequence. pc_load appears only in that cycle, and only for calls and returns.
- R11: ram_we and ram_re are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_call_far | input | 1 | Far (16-bit target) call request |
| req_call_page | input | 1 | Page (11-bit target) call request |
| req_ret | input | 1 | Subroutine return request |
| req_ret_irq | input | 1 | Interrupt return request |
| req_push | input | 1 | Byte push request |
| req_pop | input | 1 | Byte pop request |
| next_pc | input | 16 | Address of the instruction after the call |
| call_tgt | input | 16 | Call target (only bits 10:0 are used for a page call) |
| dir_addr | input | 8 | Direct destination address for a pop |
| push_data | input | 8 | Byte to push |
| ram_rdata | input | 8 | RAM read data, valid one cycle after ram_re |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| sp | output | 8 | Current stack pointer |
| pc_load | output | 1 | Load pc_new into the program counter |
| pc_new | output | 16 | New program counter value |
| irq_release | output | 1 | Release the in-service interrupt level |
| done | output | 1 | Final cycle of a sequence |

## Verification
Every RAM strobe, address and data value appears combinationally from the registered state. A push result is therefore due in the first cycle after the accepting edge. A call or pop finishes in the second cycle, and a return finishes in the third. The stack pointer reflects each step at the edge that closes that cycle. The bench drives requests on falling edges and samples each cycle of a sequence on the next falling edge. It checks the stack pointer one further falling edge after the final cycle. Its RAM model applies the one-cycle read latency, so the bench derives return addresses and popped bytes arithmetically, from what it pushed and from how it tracked the stack pointer.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CALL_LO,
        ST_CALL_HI,
        ST_RET_HI,
        ST_RET_LO,
        ST_RET_FIN,
        ST_PUSH_WR,
        ST_POP_RD,
        ST_POP_WR
    } stk_state_t;
endpackage

// File: rtl/stk_sp.sv
module stk_sp #(
    parameter int AW = 8,
    parameter logic [AW-1:0] SP_INIT = 8'h07
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [AW-1:0] sp
);
    localparam logic [AW-1:0] ONE = AW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)   sp <= SP_INIT;
        else if (inc) sp <= sp + ONE;
        else if (dec) sp <= sp - ONE;
    end

    AST_SP_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n) !(inc && dec)); // R8
    AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sp != $past(sp)) |-> ((sp == AW'($past(sp) + ONE)) || (sp == AW'($past(sp) - ONE)))); // R8
endmodule

// File: rtl/stk_frame.sv
module stk_frame #(
    parameter int DW    = 8,
    parameter int AW    = 8,
    parameter int PCW   = 16,
    parameter int PAGEW = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           accept,
    input  logic           req_far,
    input  logic           req_page,
    input  logic           req_ret,
    input  logic           req_ret_irq,
    input  logic [PCW-1:0] next_pc,
    input  logic [PCW-1:0] call_tgt,
    input  logic [AW-1:0]  dir_addr,
    input  logic [DW-1:0]  push_data,
    input  logic           cap_hi,
    input  logic [DW-1:0]  ram_rdata,
    output logic [PCW-1:0] ret_addr_q,
    output logic [PCW-1:0] tgt_q,
    output logic [AW-1:0]  dir_q,
    output logic [DW-1:0]  pdata_q,
    output logic [DW-1:0]  hi_q,
    output logic           irq_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_addr_q <= '0;
            tgt_q      <= '0;
            dir_q      <= '0;
            pdata_q    <= '0;
            hi_q       <= '0;
            irq_q      <= 1'b0;
        end else begin
            if (accept) begin
                ret_addr_q <= next_pc;
                tgt_q      <= req_far ? call_tgt
                                      : {next_pc[PCW-1:PAGEW], call_tgt[PAGEW-1:0]};
                dir_q      <= dir_addr;
                pdata_q    <= push_data;
                irq_q      <= req_ret_irq && !req_ret && !req_far && !req_page;
            end
            if (cap_hi) hi_q <= ram_rdata;
        end
    end
endmodule

// File: rtl/stk_fsm.sv
module stk_fsm
    import stk_pkg::*;
#(
    parameter int DW  = 8,
    parameter int AW  = 8,
    parameter int PCW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_far,
    input  logic           req_page,
    input  logic           req_ret,
    input  logic           req_ret_irq,
    input  logic           req_push,
    input  logic           req_pop,
    input  logic [AW-1:0]  sp,
    input  logic [PCW-1:0] ret_addr_q,
    input  logic [PCW-1:0] tgt_q,
    input  logic [AW-1:0]  dir_q,
    input  logic [DW-1:0]  pdata_q,
    input  logic [DW-1:0]  hi_q,
    input  logic           irq_q,
    input  logic [DW-1:0]  ram_rdata,
    output logic           accept,
    output logic           sp_inc,
    output logic           sp_dec,
    output logic           cap_hi,
    output logic           ram_we,
    output logic           ram_re,
    output logic [AW-1:0]  ram_addr,
    output logic [DW-1:0]  ram_wdata,
    output logic           pc_load,
    output logic [PCW-1:0] pc_new,
    output logic           irq_release,
    output logic           done
);
    localparam logic [AW-1:0] ONE = AW'(1);

    stk_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        accept      = 1'b0;
        sp_inc      = 1'b0;
        sp_dec      = 1'b0;
        cap_hi      = 1'b0;
        ram_we      = 1'b0;
        ram_re      = 1'b0;
        ram_addr    = sp;
        ram_wdata   = '0;
        pc_load     = 1'b0;
        pc_new      = '0;
        irq_release = 1'b0;
        done        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept = req_far || req_page || req_ret || req_ret_irq || req_push || req_pop;
                if (req_far || req_page)         state_d = ST_CALL_LO;
                else if (req_ret || req_ret_irq) state_d = ST_RET_HI;
                else if (req_push)               state_d = ST_PUSH_WR;
                else if (req_pop)                state_d = ST_POP_RD;
            end
            ST_CALL_LO: begin
                ram_we    = 1'b1;
                ram_addr  = sp + ONE;
                ram_wdata = ret_addr_q[DW-1:0];
                sp_inc    = 1'b1;
                state_d   = ST_CALL_HI;
            end
            ST_CALL_HI: begin
                ram_we    = 1'b1;
                ram_addr  = sp + ONE;
                ram_wdata = ret_addr_q[PCW-1:DW];
                sp_inc    = 1'b1;
                pc_load   = 1'b1;
                pc_new    = tgt_q;
                done      = 1'b1;
                state_d   = ST_IDLE;
            end
            ST_RET_HI: begin
                ram_re  = 1'b1;
                sp_dec  = 1'b1;
                state_d = ST_RET_LO;
            end
            ST_RET_LO: begin
                ram_re  = 1'b1;
                sp_dec  = 1'b1;
                cap_hi  = 1'b1;
                state_d = ST_RET_FIN;
            end
            ST_RET_FIN: begin
                pc_load     = 1'b1;
                pc_new      = {hi_q, ram_rdata};
                irq_release = irq_q;
                done        = 1'b1;
                state_d     = ST_IDLE;
            end
            ST_PUSH_WR: begin
                ram_we    = 1'b1;
                ram_addr  = sp + ONE;
                ram_wdata = pdata_q;
                sp_inc    = 1'b1;
                done      = 1'b1;
                state_d   = ST_IDLE;
            end
            ST_POP_RD: begin
                ram_re  = 1'b1;
                sp_dec  = 1'b1;
                state_d = ST_POP_WR;
            end
            ST_POP_WR: begin
                ram_we    = 1'b1;
                ram_addr  = dir_q;
                ram_wdata = ram_rdata;
                done      = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) !(ram_we && ram_re)); // R11
    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> (state_q == ST_IDLE)); // R10
    AST_PCLOAD_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n) pc_load |-> done); // R10
    AST_RELEASE_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_n) irq_release |-> (pc_load && !ram_we)); // R5
    AST_CALL_TWO_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CALL_LO) |=> (state_q == ST_CALL_HI && ram_we)); // R2
    AST_RET_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RET_HI) |=> (ram_re && ram_addr == AW'($past(ram_addr) - ONE))); // R4
endmodule

// File: rtl/callstack_ctrl.sv
module callstack_ctrl #(
    parameter int DW    = 8,
    parameter int AW    = 8,
    parameter int PAGEW = 11,
    parameter logic [AW-1:0] SP_INIT = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_call_far,
    input  logic              req_call_page,
    input  logic              req_ret,
    input  logic              req_ret_irq,
    input  logic              req_push,
    input  logic              req_pop,
    input  logic [2*DW-1:0]   next_pc,
    input  logic [2*DW-1:0]   call_tgt,
    input  logic [AW-1:0]     dir_addr,
    input  logic [DW-1:0]     push_data,
    input  logic [DW-1:0]     ram_rdata,
    output logic              ram_we,
    output logic              ram_re,
    output logic [AW-1:0]     ram_addr,
    output logic [DW-1:0]     ram_wdata,
    output logic [AW-1:0]     sp,
    output logic              pc_load,
    output logic [2*DW-1:0]   pc_new,
    output logic              irq_release,
    output logic              done
);
    localparam int PCW = 2 * DW;

    logic           accept, sp_inc, sp_dec, cap_hi, irq_q;
    logic [PCW-1:0] ret_addr_q, tgt_q;
    logic [AW-1:0]  dir_q;
    logic [DW-1:0]  pdata_q, hi_q;

    stk_sp #(.AW(AW), .SP_INIT(SP_INIT)) u_sp (
        .clk(clk), .rst_n(rst_n), .inc(sp_inc), .dec(sp_dec), .sp(sp)
    );

    stk_frame #(.DW(DW), .AW(AW), .PCW(PCW), .PAGEW(PAGEW)) u_frame (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .req_far(req_call_far), .req_page(req_call_page),
        .req_ret(req_ret), .req_ret_irq(req_ret_irq),
        .next_pc(next_pc), .call_tgt(call_tgt), .dir_addr(dir_addr),
        .push_data(push_data), .cap_hi(cap_hi), .ram_rdata(ram_rdata),
        .ret_addr_q(ret_addr_q), .tgt_q(tgt_q), .dir_q(dir_q),
        .pdata_q(pdata_q), .hi_q(hi_q), .irq_q(irq_q)
    );

    stk_fsm #(.DW(DW), .AW(AW), .PCW(PCW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_far(req_call_far), .req_page(req_call_page),
        .req_ret(req_ret), .req_ret_irq(req_ret_irq),
        .req_push(req_push), .req_pop(req_pop),
        .sp(sp), .ret_addr_q(ret_addr_q), .tgt_q(tgt_q), .dir_q(dir_q),
        .pdata_q(pdata_q), .hi_q(hi_q), .irq_q(irq_q), .ram_rdata(ram_rdata),
        .accept(accept), .sp_inc(sp_inc), .sp_dec(sp_dec), .cap_hi(cap_hi),
        .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .pc_load(pc_load), .pc_new(pc_new), .irq_release(irq_release), .done(done)
    );
endmodule

// File: tb/sim_callstack_ctrl.sv
`timescale 1ns/1ps
module sim_callstack_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        r_far = 0, r_page = 0, r_ret = 0, r_irq = 0, r_push = 0, r_pop = 0;
    logic [15:0] next_pc = '0, call_tgt = '0;
    logic [7:0]  dir_addr = '0, push_data = '0, ram_rdata = '0;
    logic        ram_we, ram_re, pc_load, irq_release, done;
    logic [7:0]  ram_addr, ram_wdata, sp;
    logic [15:0] pc_new;

    logic [7:0]  mem [256];
    logic [7:0]  exp_sp = 8'h07;
    int          n_tests = 0, n_fail = 0;

    always #4 clk = ~clk;

    callstack_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_call_far(r_far), .req_call_page(r_page),
        .req_ret(r_ret), .req_ret_irq(r_irq), .req_push(r_push), .req_pop(r_pop),
        .next_pc(next_pc), .call_tgt(call_tgt), .dir_addr(dir_addr), .push_data(push_data),
        .ram_rdata(ram_rdata), .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .sp(sp), .pc_load(pc_load), .pc_new(pc_new),
        .irq_release(irq_release), .done(done)
    );

    always_ff @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        if (ram_re) ram_rdata <= mem[ram_addr];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_push(input logic [7:0] d);
        @(negedge clk); push_data = d; r_push = 1;
        @(negedge clk); r_push = 0;
        chk("R6 push we", ram_we, 1);
        chk("R6 push addr", ram_addr, 8'(exp_sp + 8'd1));
        chk("R6 push data", ram_wdata, d);
        chk("R10 push done", done, 1);
        chk("R10 push no pc_load", pc_load, 0);
        exp_sp = 8'(exp_sp + 8'd1);
        @(negedge clk);
        chk("R6 push sp", sp, exp_sp);
        chk("R10 done one cycle", done, 0);
    endtask

    task automatic do_pop(input logic [7:0] da);
        logic [7:0] ed;
        ed = mem[exp_sp];
        @(negedge clk); dir_addr = da; r_pop = 1;
        @(negedge clk); r_pop = 0;
        chk("R7 pop re", ram_re, 1);
        chk("R7 pop rd addr", ram_addr, exp_sp);
        chk("R11 pop no we", ram_we, 0);
        @(negedge clk);
        chk("R7 pop we", ram_we, 1);
        chk("R7 pop dst", ram_addr, da);
        chk("R7 pop data", ram_wdata, ed);
        chk("R10 pop done", done, 1);
        exp_sp = 8'(exp_sp - 8'd1);
        @(negedge clk);
        chk("R7 pop sp", sp, exp_sp);
    endtask

    task automatic do_call(input bit far, input logic [15:0] npc, input logic [15:0] tgt,
                           input bit busy_req);
        logic [15:0] ept;
        ept = far ? tgt : {npc[15:11], tgt[10:0]};
        @(negedge clk); next_pc = npc; call_tgt = tgt; r_far = far; r_page = !far;
        @(negedge clk); r_far = 0; r_page = 0; r_pop = busy_req; r_push = busy_req;
        chk("R2 call lo we", ram_we, 1);
        chk("R2 call lo addr", ram_addr, 8'(exp_sp + 8'd1));
        chk("R2 call lo data", ram_wdata, npc[7:0]);
        chk("R10 call lo no done", done, 0);
        @(negedge clk);
        chk("R2 call hi addr", ram_addr, 8'(exp_sp + 8'd2));
        chk("R2 call hi data", ram_wdata, npc[15:8]);
        chk("R10 call pc_load", pc_load, 1);
        if (far) chk("R2 far target", pc_new, ept);
        else     chk("R3 page target", pc_new, ept);
        r_pop = 0; r_push = 0;
        exp_sp = 8'(exp_sp + 8'd2);
        @(negedge clk);
        chk("R2 call sp", sp, exp_sp);
        if (busy_req) begin
            chk("R9 busy req ignored we", ram_we, 0);
            chk("R9 busy req ignored re", ram_re, 0);
        end
    endtask

    task automatic do_ret(input bit irq, input logic [15:0] epc);
        @(negedge clk); r_ret = !irq; r_irq = irq;
        @(negedge clk); r_ret = 0; r_irq = 0;
        chk("R4 ret re1", ram_re, 1);
        chk("R4 ret addr1", ram_addr, exp_sp);
        chk("R5 ret no we1", ram_we, 0);
        chk("R5 no early release", irq_release, 0);
        @(negedge clk);
        chk("R4 ret addr2", ram_addr, 8'(exp_sp - 8'd1));
        chk("R5 ret no we2", ram_we, 0);
        @(negedge clk);
        chk("R4 ret pc_load", pc_load, 1);
        chk("R4 ret pc", pc_new, epc);
        chk("R5 release", irq_release, irq);
        chk("R5 ret no we3", ram_we, 0);
        chk("R10 ret done", done, 1);
        exp_sp = 8'(exp_sp - 8'd2);
        @(negedge clk);
        chk("R4 ret sp", sp, exp_sp);
        chk("R5 release one cycle", irq_release, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 reset sp", sp, 8'h07);
        chk("R1 reset we", ram_we, 0);
        chk("R1 reset re", ram_re, 0);
        chk("R1 reset done", done, 0);
        chk("R1 reset pc_load", pc_load, 0);
        chk("R1 reset release", irq_release, 0);
        rst_n = 1;

        do_push(8'hA5);
        do_call(1, 16'h1234, 16'hBEEF, 0);
        do_call(0, 16'h3FFE, 16'hFABC, 0);
        do_ret(1, 16'h3FFE);
        do_ret(0, 16'h1234);
        do_pop(8'h30);
        chk("R7 popped byte stored", mem[8'h30], 8'hA5);

        // R9: requests during a call are ignored
        do_call(1, 16'h0042, 16'h0100, 1);
        do_ret(0, 16'h0042);

        // R9: priority between simultaneous requests
        @(negedge clk); push_data = 8'h5C; r_push = 1; r_pop = 1;
        @(negedge clk); r_push = 0; r_pop = 0;
        chk("R9 push beats pop", ram_we, 1);
        chk("R9 push beats pop addr", ram_addr, 8'(exp_sp + 8'd1));
        exp_sp = 8'(exp_sp + 8'd1);
        @(negedge clk);
        next_pc = 16'h2222; call_tgt = 16'h7777; r_far = 1; r_ret = 1; r_irq = 1;
        @(negedge clk); r_far = 0; r_ret = 0; r_irq = 0;
        chk("R9 call beats return", ram_we, 1);
        @(negedge clk);
        chk("R9 far beats others", pc_new, 16'h7777);
        exp_sp = 8'(exp_sp + 8'd2);
        do_ret(0, 16'h2222);
        @(negedge clk); next_pc = 16'hF800; call_tgt = 16'h0123; r_page = 1; r_irq = 1;
        @(negedge clk); r_page = 0; r_irq = 0;
        @(negedge clk);
        chk("R9 page beats irq return", pc_new, 16'hF923);
        exp_sp = 8'(exp_sp + 8'd2);
        do_ret(0, 16'hF800);

        // sweep of call/return pairs
        for (int i = 0; i < 12; i++) begin
            do_call(i[0], 16'(16'h0103 + i * 16'h1579), 16'(16'hFFF0 - i * 16'h2345), 0);
            do_ret(i[1], 16'(16'h0103 + i * 16'h1579));
        end

        // R8: wrap below zero and across the top
        while (exp_sp != 8'hFE) do_pop(8'h40);
        chk("R8 sp at FE", sp, 8'hFE);
        do_call(1, 16'hABCD, 16'h0001, 0);
        chk("R8 wrapped sp", sp, 8'h00);
        chk("R8 hi byte at 00", mem[8'h00], 8'hAB);
        chk("R8 lo byte at FF", mem[8'hFF], 8'hCD);
        do_ret(1, 16'hABCD);
        do_push(8'h3C);
        chk("R8 push wrapped", mem[8'hFF], 8'h3C);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule